// File: doc/BRIEF.md
# State-Ranked Victim Selector with Relocation Sequencer

This block serves the requesting node of a set-associative attraction memory, where local memory acts as a cache of the whole shared address space. When a reference misses, the block looks at the coherence state of every way in the addressed set. It does not use recency to pick the way to evict. It uses a fixed ranking of states: invalid is evicted first, then shared non-owner, then shared owner, then exclusive. A victim that holds ownership may be the last copy in the system, so it has to be relocated to another node rather than dropped. The block raises a flag when this is the case.

The sequencer then runs the requester side of the miss. It first issues the copy request, which fetches the missing block and also takes ownership of it. At the same time it reads the victim out of local memory into a relocation buffer, together with the victim's coherence state. When the missing data arrives, the processor is told it may resume. If relocation is needed, the relocate request follows at once, and the bus is held the whole time from the copy request to the relocate request. A new miss is refused while a sequence is in progress. The remote side, which decides where the relocated block lands, is not part of this block.

Top module: `victim_reloc_ctrl`

## Requirements
- R1: Each way's state is a 2-bit field of `way_state_i`, with way w at bits [2w+1:2w]. The codes are invalid=0, shared non-owner=1, shared owner=2 and exclusive=3, and the numeric code is the eviction rank. `victim_way_o` names a way whose state, sampled at the accepted miss, has the lowest code in the set.
- R2: When several ways share the lowest code, the lowest way index is chosen.
- R3: `reloc_need_o` is 1 exactly when the chosen victim is shared owner or exclusive. The flag and `victim_way_o` are latched at the accepted miss and stay unchanged until the next accepted miss.
- R4: The cycle after a miss is accepted, `copy_req_o` is high for exactly one cycle. `victim_rd_o` is high in that same cycle when relocation is needed, and stays low otherwise.
- R5: When relocation is needed, the victim data and the victim's state are captured on `rbuf_data_o` and `rbuf_state_o` in the cycle after `fetch_done_i` is seen during the fetch phase. The fetch phase does not end until `fetch_done_i` has been seen.
- R6: When relocation is needed, `reloc_req_o` is high for one cycle, in the cycle after the fill is seen during the wait phase. `resume_o` is high in that same cycle.
- R7: When no relocation is needed, the fetch phase lasts one cycle and `fetch_done_i` is not required. `reloc_req_o` never rises, and `resume_o` pulses once, one cycle after the fill is seen.
- R8: `bus_hold_o` is high without a gap from the `copy_req_o` cycle through the `reloc_req_o` cycle (or through the wait phase when there is no relocation). It drops in the closing cycle that follows.
- R9: `busy_o` is high from the cycle after an accepted miss until the sequence returns to idle. A `miss_i` seen while busy is ignored: it does not change the latched way or flag, and it does not start a new copy request.
- R10: A `fill_arrived_i` pulse that arrives during the fetch phase is remembered, and the sequence moves on without a second fill.
- R11: While reset is active, and after it is released, the block is idle and every strobe, `busy_o`, `reloc_need_o` and `victim_way_o` are 0. A reset in the middle of a sequence abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_i | input | 1 | Reference miss; accepted only while idle |
| way_state_i | input | 2*NWAYS | Coherence state of each way of the missed set |
| fetch_done_i | input | 1 | Victim read from local memory has returned data |
| fill_arrived_i | input | 1 | Missing block has arrived from the bus |
| victim_data_i | input | DATA_W | Victim block data from local memory |
| busy_o | output | 1 | Sequence in progress; misses are refused |
| victim_way_o | output | WAY_W | Chosen victim way |
| reloc_need_o | output | 1 | Victim holds ownership and must be relocated |
| victim_rd_o | output | 1 | Pulse that starts the victim read |
| copy_req_o | output | 1 | Pulse for the ownership-taking copy fetch |
| reloc_req_o | output | 1 | Pulse that starts the relocate transaction |
| bus_hold_o | output | 1 | Keep bus tenure across copy and relocate |
| resume_o | output | 1 | Pulse: the processor may continue with the fill data |
| rbuf_data_o | output | DATA_W | Relocation buffer data |
| rbuf_state_o | output | 2 | Relocation buffer coherence state |

## Verification
Some rules are checked by the assertions on every cycle. The chosen way must have the minimum state code of the set sampled at the miss. The copy and relocate strobes must each last a single cycle and never overlap. A relocate must only happen with the flag set, with resume asserted and with the bus held on both sides. The latched way must not move while busy. Other properties only show up in the bench's scenarios: the exact cycle each pulse appears, the values captured in the relocation buffer, a fill remembered from the fetch phase, a miss ignored while busy, and a reset that abandons a sequence.

// File: rtl/vrs_pkg.sv
// Shared types for the victim selector and relocation sequencer.
// Assumes the coherence code value doubles as eviction rank.
package vrs_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'd0,
        ST_SHN = 2'd1,
        ST_SHO = 2'd2,
        ST_EXL = 2'd3
    } coh_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_FETCH, SQ_WAIT_FILL, SQ_RELOCATE, SQ_DONE
    } seq_t;

    // Ownership-holding states must be relocated, never dropped.
    function automatic logic owns_block(coh_t s);
        return (s == ST_SHO) || (s == ST_EXL);
    endfunction
endpackage

// File: rtl/victim_pick.sv
// Combinational victim picker: lowest state code wins, ties go to the
// lowest way index. Assumes NWAYS >= 2.
module victim_pick
    import vrs_pkg::*;
#(
    parameter int NWAYS = 4,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic [2*NWAYS-1:0] states_i,
    output logic [WAY_W-1:0]   way_o,
    output coh_t               state_o,
    output logic               reloc_o
);
    coh_t st_arr [NWAYS];

    for (genvar g = 0; g < NWAYS; g++) begin : g_unpack
        assign st_arr[g] = coh_t'(states_i[2*g +: 2]);
    end

    // Scan from the top way down so that equal ranks resolve to the lower index.
    always_comb begin
        way_o   = WAY_W'(NWAYS - 1);
        state_o = st_arr[NWAYS-1];
        for (int i = NWAYS - 2; i >= 0; i--) begin
            if (st_arr[i] <= state_o) begin
                state_o = st_arr[i];
                way_o   = WAY_W'(i);
            end
        end
        reloc_o = owns_block(state_o);
    end
endmodule

// File: rtl/reloc_buf.sv
// Relocation buffer: holds the victim block and its coherence state
// from the victim read until the relocate transaction drains it.
module reloc_buf
    import vrs_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  coh_t              state_i,
    output logic [DATA_W-1:0] data_o,
    output coh_t              state_o
);
    // Capture victim data and state on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o  <= '0;
            state_o <= ST_INV;
        end else if (load_i) begin
            data_o  <= data_i;
            state_o <= state_i;
        end
    end
endmodule

// File: rtl/reloc_seq.sv
// Requester-side miss sequencer. It issues the copy fetch and the victim
// read together, waits for the victim data (when relocating) and for the
// fill, then issues the relocate under the same bus tenure.
// Assumes fill_i and fetch_done_i are single-cycle pulses.
module reloc_seq
    import vrs_pkg::*;
#(
    parameter int NWAYS = 4,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic [WAY_W-1:0] pick_way_i,
    input  coh_t             pick_state_i,
    input  logic             pick_reloc_i,
    input  logic             fetch_done_i,
    input  logic             fill_i,
    output logic             busy_o,
    output logic [WAY_W-1:0] way_o,
    output coh_t             vstate_o,
    output logic             reloc_o,
    output logic             copy_req_o,
    output logic             victim_rd_o,
    output logic             reloc_req_o,
    output logic             bus_hold_o,
    output logic             resume_o,
    output logic             buf_load_o
);
    seq_t state_q;
    logic first_q;
    logic fill_seen_q;
    logic resume_q;

    // State register, latched victim choice and the fill/resume flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            way_o       <= '0;
            vstate_o    <= ST_INV;
            reloc_o     <= 1'b0;
            first_q     <= 1'b0;
            fill_seen_q <= 1'b0;
            resume_q    <= 1'b0;
        end else begin
            resume_q <= 1'b0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (miss_i) begin
                        state_q     <= SQ_FETCH;
                        way_o       <= pick_way_i;
                        vstate_o    <= pick_state_i;
                        reloc_o     <= pick_reloc_i;
                        first_q     <= 1'b1;
                        fill_seen_q <= 1'b0;
                    end
                end
                SQ_FETCH: begin
                    first_q <= 1'b0;
                    if (fill_i) fill_seen_q <= 1'b1;
                    if (!reloc_o || fetch_done_i) state_q <= SQ_WAIT_FILL;
                end
                SQ_WAIT_FILL: begin
                    if (fill_i || fill_seen_q) begin
                        state_q  <= reloc_o ? SQ_RELOCATE : SQ_DONE;
                        resume_q <= 1'b1;
                    end
                end
                SQ_RELOCATE: state_q <= SQ_DONE;
                SQ_DONE:     state_q <= SQ_IDLE;
                default:     state_q <= SQ_IDLE;
            endcase
        end
    end

    // Output decode from the current phase.
    always_comb begin
        busy_o      = (state_q != SQ_IDLE);
        copy_req_o  = (state_q == SQ_FETCH) && first_q;
        victim_rd_o = copy_req_o && reloc_o;
        buf_load_o  = (state_q == SQ_FETCH) && reloc_o && fetch_done_i;
        reloc_req_o = (state_q == SQ_RELOCATE);
        bus_hold_o  = (state_q == SQ_FETCH) || (state_q == SQ_WAIT_FILL)
                   || (state_q == SQ_RELOCATE);
        resume_o    = resume_q;
    end
endmodule

// File: rtl/victim_reloc_ctrl.sv
// Top: state-ranked victim selection plus requester relocation sequence.
// Assumes the set's way states are valid in the cycle miss_i is high.
module victim_reloc_ctrl
    import vrs_pkg::*;
#(
    parameter int NWAYS  = 4,
    parameter int DATA_W = 64,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_i,
    input  logic [2*NWAYS-1:0] way_state_i,
    input  logic              fetch_done_i,
    input  logic              fill_arrived_i,
    input  logic [DATA_W-1:0] victim_data_i,
    output logic              busy_o,
    output logic [WAY_W-1:0]  victim_way_o,
    output logic              reloc_need_o,
    output logic              victim_rd_o,
    output logic              copy_req_o,
    output logic              reloc_req_o,
    output logic              bus_hold_o,
    output logic              resume_o,
    output logic [DATA_W-1:0] rbuf_data_o,
    output logic [1:0]        rbuf_state_o
);
    logic [WAY_W-1:0] pick_way;
    coh_t             pick_state;
    logic             pick_reloc;
    coh_t             vstate;
    logic             buf_load;
    coh_t             rbuf_state;

    victim_pick #(.NWAYS(NWAYS)) u_pick (
        .states_i (way_state_i),
        .way_o    (pick_way),
        .state_o  (pick_state),
        .reloc_o  (pick_reloc)
    );

    reloc_seq #(.NWAYS(NWAYS)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .miss_i       (miss_i),
        .pick_way_i   (pick_way),
        .pick_state_i (pick_state),
        .pick_reloc_i (pick_reloc),
        .fetch_done_i (fetch_done_i),
        .fill_i       (fill_arrived_i),
        .busy_o       (busy_o),
        .way_o        (victim_way_o),
        .vstate_o     (vstate),
        .reloc_o      (reloc_need_o),
        .copy_req_o   (copy_req_o),
        .victim_rd_o  (victim_rd_o),
        .reloc_req_o  (reloc_req_o),
        .bus_hold_o   (bus_hold_o),
        .resume_o     (resume_o),
        .buf_load_o   (buf_load)
    );

    reloc_buf #(.DATA_W(DATA_W)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (buf_load),
        .data_i  (victim_data_i),
        .state_i (vstate),
        .data_o  (rbuf_data_o),
        .state_o (rbuf_state)
    );

    assign rbuf_state_o = rbuf_state;
endmodule

// File: rtl/victim_reloc_ctrl_chk.sv
// Checker bound to victim_reloc_ctrl: watches the port-level protocol.
module victim_reloc_ctrl_chk #(
    parameter int NWAYS = 4,
    localparam int WAY_W = (NWAYS > 1) ? $clog2(NWAYS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               miss_i,
    input logic [2*NWAYS-1:0] way_state_i,
    input logic               busy_o,
    input logic [WAY_W-1:0]   victim_way_o,
    input logic               reloc_need_o,
    input logic               copy_req_o,
    input logic               reloc_req_o,
    input logic               bus_hold_o,
    input logic               resume_o
);
    logic [2*NWAYS-1:0] states_q;
    logic [1:0]         min_code;
    logic [1:0]         way_code;

    // Remember the set states of the previous cycle (the accepted miss).
    always_ff @(posedge clk) begin
        if (!rst_n) states_q <= '0;
        else        states_q <= way_state_i;
    end

    // Lowest code present in the remembered set, and the victim's code.
    always_comb begin
        min_code = 2'd3;
        for (int i = 0; i < NWAYS; i++)
            if (states_q[2*i +: 2] < min_code) min_code = states_q[2*i +: 2];
        way_code = states_q[2*victim_way_o +: 2];
    end

    AST_MIN_RANK_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req_o |-> (way_code == min_code)); // R1
    AST_FLAG_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req_o |-> (reloc_need_o == way_code[1])); // R3
    AST_COPY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req_o |=> !copy_req_o); // R4
    AST_RELOC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_req_o |=> !reloc_req_o); // R6
    AST_RELOC_WITH_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_req_o |-> (resume_o && reloc_need_o)); // R6
    AST_NO_RELOC_WITHOUT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !reloc_need_o |-> !reloc_req_o); // R7
    AST_TENURE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        reloc_req_o |-> (bus_hold_o && $past(bus_hold_o))); // R8
    AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
        !(copy_req_o && reloc_req_o)); // R8
    AST_WAY_HELD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(victim_way_o) && $stable(reloc_need_o))); // R9
    AST_COPY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        copy_req_o |-> (busy_o && bus_hold_o)); // R9
endmodule

bind victim_reloc_ctrl victim_reloc_ctrl_chk #(.NWAYS(NWAYS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_i       (miss_i),
    .way_state_i  (way_state_i),
    .busy_o       (busy_o),
    .victim_way_o (victim_way_o),
    .reloc_need_o (reloc_need_o),
    .copy_req_o   (copy_req_o),
    .reloc_req_o  (reloc_req_o),
    .bus_hold_o   (bus_hold_o),
    .resume_o     (resume_o)
);

// File: tb/victim_reloc_ctrl_bench.sv
// Self-checking bench: a vector table of set states walked through full
// miss sequences, then directed tests for reset, early fill and busy misses.
module victim_reloc_ctrl_bench;
    localparam int NWAYS  = 4;
    localparam int DATA_W = 64;
    localparam int WAY_W  = 2;
    localparam int NVEC   = 8;

    // {set states (way3..way0), expected way, expected relocation flag}
    localparam logic [10:0] VEC [NVEC] = '{
        {8'h00, 2'd0, 1'b0},
        {8'h1B, 2'd3, 1'b0},
        {8'h5B, 2'd2, 1'b0},
        {8'hBB, 2'd1, 1'b1},
        {8'hFF, 2'd0, 1'b1},
        {8'hBF, 2'd3, 1'b1},
        {8'hC2, 2'd1, 1'b0},
        {8'hE5, 2'd0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              miss_i = 1'b0;
    logic [2*NWAYS-1:0] way_state_i = '0;
    logic              fetch_done_i = 1'b0;
    logic              fill_arrived_i = 1'b0;
    logic [DATA_W-1:0] victim_data_i = '0;
    logic              busy_o, reloc_need_o, victim_rd_o, copy_req_o;
    logic              reloc_req_o, bus_hold_o, resume_o;
    logic [WAY_W-1:0]  victim_way_o;
    logic [DATA_W-1:0] rbuf_data_o;
    logic [1:0]        rbuf_state_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    victim_reloc_ctrl #(.NWAYS(NWAYS), .DATA_W(DATA_W)) u_victim_reloc_ctrl (
        .clk(clk), .rst_n(rst_n), .miss_i(miss_i), .way_state_i(way_state_i),
        .fetch_done_i(fetch_done_i), .fill_arrived_i(fill_arrived_i),
        .victim_data_i(victim_data_i), .busy_o(busy_o),
        .victim_way_o(victim_way_o), .reloc_need_o(reloc_need_o),
        .victim_rd_o(victim_rd_o), .copy_req_o(copy_req_o),
        .reloc_req_o(reloc_req_o), .bus_hold_o(bus_hold_o),
        .resume_o(resume_o), .rbuf_data_o(rbuf_data_o),
        .rbuf_state_o(rbuf_state_o)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            summary();
        end
    end

    // Full sequence for one set pattern; inputs change on the falling edge.
    task automatic run_miss(input logic [7:0] st, input logic [1:0] ew,
                            input logic er, input logic [63:0] d);
        logic [1:0] ecode;
        ecode = st[2*ew +: 2];
        @(negedge clk); miss_i = 1'b1; way_state_i = st;
        @(negedge clk); miss_i = 1'b0;
        check("R1", "victim way", victim_way_o, ew);
        check("R2", "victim way tie", victim_way_o, ew);
        check("R3", "relocate flag", reloc_need_o, er);
        check("R4", "copy pulse", copy_req_o, 1'b1);
        check("R4", "victim read", victim_rd_o, er);
        check("R9", "busy", busy_o, 1'b1);
        fetch_done_i = 1'b1; victim_data_i = d;
        @(negedge clk); fetch_done_i = 1'b0;
        check("R4", "copy pulse ends", copy_req_o, 1'b0);
        check("R8", "bus held in wait", bus_hold_o, 1'b1);
        if (er) begin
            check("R5", "buffer data", rbuf_data_o, d);
            check("R5", "buffer state", rbuf_state_o, ecode);
        end
        fill_arrived_i = 1'b1;
        @(negedge clk); fill_arrived_i = 1'b0;
        check("R6", "resume", resume_o, 1'b1);
        check("R7", "relocate only when needed", reloc_req_o, er);
        check("R8", "hold tracks relocate", bus_hold_o, er);
        if (er) begin
            @(negedge clk);
            check("R6", "relocate single", reloc_req_o, 1'b0);
            check("R8", "hold released", bus_hold_o, 1'b0);
        end
        @(negedge clk);
        check("R9", "idle again", busy_o, 1'b0);
    endtask

    initial begin
        // R11: reset state.
        repeat (3) @(negedge clk);
        check("R11", "busy in reset", busy_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "busy", busy_o, 1'b0);
        check("R11", "copy", copy_req_o, 1'b0);
        check("R11", "relocate", reloc_req_o, 1'b0);
        check("R11", "hold", bus_hold_o, 1'b0);
        check("R11", "resume", resume_o, 1'b0);
        check("R11", "flag", reloc_need_o, 1'b0);
        check("R11", "way", victim_way_o, 2'd0);

        for (int i = 0; i < NVEC; i++)
            run_miss(VEC[i][10:3], VEC[i][2:1], VEC[i][0],
                     64'h5A00_0000_0000_0000 + 64'(i) * 64'h0101);

        // R5, R10, R9: late victim data, fill during fetch, miss while busy.
        @(negedge clk); miss_i = 1'b1; way_state_i = 8'hBF;
        @(negedge clk); miss_i = 1'b0;
        check("R4", "copy pulse", copy_req_o, 1'b1);
        @(negedge clk);
        check("R4", "no second copy", copy_req_o, 1'b0);
        check("R5", "fetch waits for data", bus_hold_o, 1'b1);
        check("R6", "no early relocate", reloc_req_o, 1'b0);
        fill_arrived_i = 1'b1;
        @(negedge clk); fill_arrived_i = 1'b0;
        fetch_done_i = 1'b1; victim_data_i = 64'hDEAD_BEEF_0123_4567;
        @(negedge clk); fetch_done_i = 1'b0;
        check("R5", "late buffer data", rbuf_data_o, 64'hDEAD_BEEF_0123_4567);
        check("R5", "late buffer state", rbuf_state_o, 2'd2);
        check("R6", "relocate waits a cycle", reloc_req_o, 1'b0);
        miss_i = 1'b1; way_state_i = 8'h00;
        @(negedge clk);
        check("R10", "remembered fill starts relocate", reloc_req_o, 1'b1);
        check("R9", "way held while busy", victim_way_o, 2'd3);
        check("R9", "flag held while busy", reloc_need_o, 1'b1);
        @(negedge clk);
        check("R9", "no copy while busy", copy_req_o, 1'b0);
        miss_i = 1'b0;
        @(negedge clk);
        check("R9", "returned idle", busy_o, 1'b0);
        check("R9", "ignored miss left way", victim_way_o, 2'd3);

        // R7: fill arriving in the single fetch cycle of a no-relocate miss.
        @(negedge clk); miss_i = 1'b1; way_state_i = 8'hE5;
        @(negedge clk); miss_i = 1'b0; fill_arrived_i = 1'b1;
        @(negedge clk); fill_arrived_i = 1'b0;
        check("R7", "fetch skipped without data", bus_hold_o, 1'b1);
        @(negedge clk);
        check("R7", "resume", resume_o, 1'b1);
        check("R7", "no relocate", reloc_req_o, 1'b0);
        check("R8", "hold dropped", bus_hold_o, 1'b0);
        @(negedge clk);

        // R11: reset in the middle of a relocating sequence.
        @(negedge clk); miss_i = 1'b1; way_state_i = 8'hFF;
        @(negedge clk); miss_i = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R11", "mid reset busy", busy_o, 1'b0);
        check("R11", "mid reset hold", bus_hold_o, 1'b0);
        check("R11", "mid reset flag", reloc_need_o, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11", "stays idle", copy_req_o, 1'b0);

        summary();
    end
endmodule